// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the 6-bit primary opcode and 6-bit function field of a 32-bit load/store RISC instruction into the control signals a single-cycle datapath needs. It has no clock and no state: every output is a pure function of the two input fields.

The outputs choose the destination register (rd, rt or the fixed return-address register), enable the register-file write, choose the write-back value (ALU result, memory data or PC+4), and choose the second ALU operand (register or immediate) along with how the immediate is extended. They also select the ALU operation, drive the memory read and write strobes, and flag a conditional branch, a register-indirect jump or an immediate-target jump. The decoded instructions are the register-to-register ALU group, jr, jalr, addi, sltiu, lw, sw, beq, j and jal. Any opcode or function code outside that set decodes to an idle word that writes nothing and touches no memory.

The opcode and function code values are parameters. Elaboration-time checks reject field widths that are too narrow and opcode assignments that collide.

Top module: `insn_ctrl_decoder`

## Requirements
- R1: With opcode 0x00 and a function code from the ALU group, the outputs are reg_wen=1, dst_sel=0 (rd), wb_sel=0 (ALU), alu_src_imm=0, no memory strobes and no flow flags. alu_op is one of these codes: add 0x20→1, addu 0x21→2, sub 0x22→3, subu 0x23→4, and 0x24→5, or 0x25→6, xor 0x26→7, nor 0x27→8, slt 0x2A→9, sltu 0x2B→10.
- R2: jr (opcode 0x00, function 0x08) sets is_jump_reg=1 and alu_op=0 (none). It writes no register and asserts no memory strobe.
- R3: jalr (opcode 0x00, function 0x09) sets is_jump_reg=1, reg_wen=1, dst_sel=0 (rd), wb_sel=2 (PC+4) and alu_op=0.
- R4: addi (0x08) and sltiu (0x0B) set alu_src_imm=1, reg_wen=1, dst_sel=1 (rt) and wb_sel=0. alu_op is 1 for addi and 10 for sltiu.
- R5: imm_zero_ext is 1 for sltiu only. For every other opcode it is 0 (sign extension).
- R6: lw (0x23) sets mem_rd=1, alu_src_imm=1, alu_op=1, reg_wen=1, dst_sel=1 (rt) and wb_sel=1 (memory).
- R7: sw (0x2B) sets mem_wr=1, alu_src_imm=1 and alu_op=1, with reg_wen=0.
- R8: beq (0x04) sets is_branch=1, alu_op=3 (subtract) and alu_src_imm=0, with reg_wen=0 and no memory strobe.
- R9: jal (0x03) sets is_jump_imm=1, reg_wen=1, dst_sel=2 (return register 31) and wb_sel=2 (PC+4), with alu_op=0.
- R10: j (0x02) sets is_jump_imm=1 and writes no register.
- R11: An unrecognised opcode gives all outputs 0.
- R12: Opcode 0x00 with an unrecognised function code gives all outputs 0.
- R13: mem_rd and mem_wr are never both 1. At most one of is_branch, is_jump_reg and is_jump_imm is 1.
- R14: For any opcode other than 0x00 the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | OPC_W | Primary opcode field |
| funct | input | FUN_W | Function field, used only when opcode is 0x00 |
| dst_sel | output | 2 | Destination: 0 rd, 1 rt, 2 return register |
| reg_wen | output | 1 | Register file write enable |
| wb_sel | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| alu_src_imm | output | 1 | Second ALU operand is the immediate |
| imm_zero_ext | output | 1 | Zero-extend the immediate (else sign-extend) |
| alu_op | output | 4 | ALU operation code (0 means none) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| is_branch | output | 1 | Conditional branch on equality |
| is_jump_reg | output | 1 | Jump to the address held in rs |
| is_jump_imm | output | 1 | Jump to the address from the target field |

## Verification
Every output is due in the same cycle as its stimulus, with zero register stages between the fields and the control word. The driver changes the fields one time unit after a rising edge and pushes the expected word. The monitor pops that word and compares all outputs at the falling edge of the same cycle, half a period after the inputs settled. The exclusivity sweep over all opcodes follows the same timing, checking each opcode at the falling edge that follows its application.

// File: rtl/insn_ctrl_pkg.sv
package insn_ctrl_pkg;

   typedef enum logic [1:0] {
      DST_RD   = 2'd0,
      DST_RT   = 2'd1,
      DST_LINK = 2'd2
   } dst_e;

   typedef enum logic [1:0] {
      WB_ALU = 2'd0,
      WB_MEM = 2'd1,
      WB_PC4 = 2'd2
   } wb_e;

   localparam int ALU_W = 4;

   typedef enum logic [ALU_W-1:0] {
      ALU_NOP  = 4'd0,
      ALU_ADD  = 4'd1,
      ALU_ADDU = 4'd2,
      ALU_SUB  = 4'd3,
      ALU_SUBU = 4'd4,
      ALU_AND  = 4'd5,
      ALU_OR   = 4'd6,
      ALU_XOR  = 4'd7,
      ALU_NOR  = 4'd8,
      ALU_SLT  = 4'd9,
      ALU_SLTU = 4'd10
   } alu_e;

   typedef struct packed {
      dst_e dst;
      logic wen;
      wb_e  wb;
      logic src_imm;
      logic zext;
      alu_e op;
      logic mrd;
      logic mwr;
      logic br;
      logic jreg;
      logic jimm;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{
      dst: DST_RD, wen: 1'b0, wb: WB_ALU, src_imm: 1'b0, zext: 1'b0,
      op: ALU_NOP, mrd: 1'b0, mwr: 1'b0, br: 1'b0, jreg: 1'b0, jimm: 1'b0
   };

endpackage

// File: rtl/insn_funct_dec.sv
module insn_funct_dec
   import insn_ctrl_pkg::*;
#(
   parameter int             FUN_W   = 6,
   parameter logic [FUN_W-1:0] FN_JR   = 'h08,
   parameter logic [FUN_W-1:0] FN_JALR = 'h09,
   parameter logic [FUN_W-1:0] FN_ADD  = 'h20,
   parameter logic [FUN_W-1:0] FN_ADDU = 'h21,
   parameter logic [FUN_W-1:0] FN_SUB  = 'h22,
   parameter logic [FUN_W-1:0] FN_SUBU = 'h23,
   parameter logic [FUN_W-1:0] FN_AND  = 'h24,
   parameter logic [FUN_W-1:0] FN_OR   = 'h25,
   parameter logic [FUN_W-1:0] FN_XOR  = 'h26,
   parameter logic [FUN_W-1:0] FN_NOR  = 'h27,
   parameter logic [FUN_W-1:0] FN_SLT  = 'h2A,
   parameter logic [FUN_W-1:0] FN_SLTU = 'h2B
) (
   input  logic [FUN_W-1:0] funct,
   output ctl_t             fctl,
   output logic             fn_known
);

   generate
      if (FUN_W < 6) begin : g_bad_width
         $error("insn_funct_dec: FUN_W must be at least 6");
      end
      if (FN_JR == FN_JALR) begin : g_bad_codes
         $error("insn_funct_dec: jr and jalr codes collide");
      end
   endgenerate

   // ALU group: a common register-to-register template, operation varies
   alu_e alu_sel;
   logic alu_hit;

   always_comb begin
      alu_hit = 1'b1;
      alu_sel = ALU_NOP;
      unique case (funct)
         FN_ADD:  alu_sel = ALU_ADD;
         FN_ADDU: alu_sel = ALU_ADDU;
         FN_SUB:  alu_sel = ALU_SUB;
         FN_SUBU: alu_sel = ALU_SUBU;
         FN_AND:  alu_sel = ALU_AND;
         FN_OR:   alu_sel = ALU_OR;
         FN_XOR:  alu_sel = ALU_XOR;
         FN_NOR:  alu_sel = ALU_NOR;
         FN_SLT:  alu_sel = ALU_SLT;
         FN_SLTU: alu_sel = ALU_SLTU;
         default: alu_hit = 1'b0;
      endcase
   end

   always_comb begin
      fctl     = CTL_IDLE;
      fn_known = 1'b1;
      if (alu_hit) begin
         fctl.wen = 1'b1;
         fctl.dst = DST_RD;
         fctl.wb  = WB_ALU;
         fctl.op  = alu_sel;
      end else if (funct == FN_JR) begin
         fctl.jreg = 1'b1;
      end else if (funct == FN_JALR) begin
         fctl.jreg = 1'b1;
         fctl.wen  = 1'b1;
         fctl.dst  = DST_RD;
         fctl.wb   = WB_PC4;
      end else begin
         fn_known = 1'b0;
      end
   end

endmodule

// File: rtl/insn_opcode_dec.sv
module insn_opcode_dec
   import insn_ctrl_pkg::*;
#(
   parameter int               OPC_W     = 6,
   parameter logic [OPC_W-1:0] OPC_RTYPE = 'h00,
   parameter logic [OPC_W-1:0] OPC_J     = 'h02,
   parameter logic [OPC_W-1:0] OPC_JAL   = 'h03,
   parameter logic [OPC_W-1:0] OPC_BEQ   = 'h04,
   parameter logic [OPC_W-1:0] OPC_ADDI  = 'h08,
   parameter logic [OPC_W-1:0] OPC_SLTIU = 'h0B,
   parameter logic [OPC_W-1:0] OPC_LW    = 'h23,
   parameter logic [OPC_W-1:0] OPC_SW    = 'h2B
) (
   input  logic [OPC_W-1:0] opcode,
   output ctl_t             octl,
   output logic             is_rtype,
   output logic             op_known
);

   localparam int N_OPC = 8;
   localparam logic [N_OPC*OPC_W-1:0] OPC_LIST =
      {OPC_RTYPE, OPC_J, OPC_JAL, OPC_BEQ, OPC_ADDI, OPC_SLTIU, OPC_LW, OPC_SW};

   generate
      if (OPC_W < 6) begin : g_bad_width
         $error("insn_opcode_dec: OPC_W must be at least 6");
      end
      for (genvar i = 0; i < N_OPC; i++) begin : g_chk_i
         for (genvar k = i + 1; k < N_OPC; k++) begin : g_chk_k
            if (OPC_LIST[i*OPC_W +: OPC_W] == OPC_LIST[k*OPC_W +: OPC_W]) begin : g_dup
               $error("insn_opcode_dec: two opcodes share one code");
            end
         end
      end
   endgenerate

   always_comb begin
      octl     = CTL_IDLE;
      is_rtype = 1'b0;
      op_known = 1'b1;
      unique case (opcode)
         OPC_RTYPE: is_rtype = 1'b1;
         OPC_J: begin
            octl.jimm = 1'b1;
         end
         OPC_JAL: begin
            octl.jimm = 1'b1;
            octl.wen  = 1'b1;
            octl.dst  = DST_LINK;
            octl.wb   = WB_PC4;
         end
         OPC_BEQ: begin
            octl.br = 1'b1;
            octl.op = ALU_SUB;
         end
         OPC_ADDI: begin
            octl.wen     = 1'b1;
            octl.dst     = DST_RT;
            octl.src_imm = 1'b1;
            octl.op      = ALU_ADD;
         end
         OPC_SLTIU: begin
            octl.wen     = 1'b1;
            octl.dst     = DST_RT;
            octl.src_imm = 1'b1;
            octl.zext    = 1'b1;
            octl.op      = ALU_SLTU;
         end
         OPC_LW: begin
            octl.wen     = 1'b1;
            octl.dst     = DST_RT;
            octl.wb      = WB_MEM;
            octl.src_imm = 1'b1;
            octl.op      = ALU_ADD;
            octl.mrd     = 1'b1;
         end
         OPC_SW: begin
            octl.src_imm = 1'b1;
            octl.op      = ALU_ADD;
            octl.mwr     = 1'b1;
         end
         default: op_known = 1'b0;
      endcase
   end

endmodule

// File: rtl/insn_ctrl_select.sv
module insn_ctrl_select
   import insn_ctrl_pkg::*;
(
   input  logic is_rtype,
   input  logic fn_known,
   input  ctl_t octl,
   input  ctl_t fctl,
   output ctl_t ctl
);

   // Function field only matters for the register group
   always_comb begin
      if (is_rtype) begin
         ctl = fn_known ? fctl : CTL_IDLE;
      end else begin
         ctl = octl;
      end
   end

endmodule

// File: rtl/insn_ctrl_decoder.sv
module insn_ctrl_decoder
   import insn_ctrl_pkg::*;
#(
   parameter int OPC_W = 6,
   parameter int FUN_W = 6
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic [FUN_W-1:0] funct,
   output logic [1:0]       dst_sel,
   output logic             reg_wen,
   output logic [1:0]       wb_sel,
   output logic             alu_src_imm,
   output logic             imm_zero_ext,
   output logic [ALU_W-1:0] alu_op,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             is_branch,
   output logic             is_jump_reg,
   output logic             is_jump_imm
);

   ctl_t octl, fctl, ctl;
   logic is_rtype, op_known, fn_known;

   insn_opcode_dec #(.OPC_W(OPC_W)) u_opc (
      .opcode   (opcode),
      .octl     (octl),
      .is_rtype (is_rtype),
      .op_known (op_known)
   );

   insn_funct_dec #(.FUN_W(FUN_W)) u_fun (
      .funct    (funct),
      .fctl     (fctl),
      .fn_known (fn_known)
   );

   insn_ctrl_select u_sel (
      .is_rtype (is_rtype),
      .fn_known (fn_known),
      .octl     (octl),
      .fctl     (fctl),
      .ctl      (ctl)
   );

   assign dst_sel      = ctl.dst;
   assign reg_wen      = ctl.wen;
   assign wb_sel       = ctl.wb;
   assign alu_src_imm  = ctl.src_imm;
   assign imm_zero_ext = ctl.zext;
   assign alu_op       = ctl.op;
   assign mem_rd       = ctl.mrd;
   assign mem_wr       = ctl.mwr;
   assign is_branch    = ctl.br;
   assign is_jump_reg  = ctl.jreg;
   assign is_jump_imm  = ctl.jimm;

   always_comb begin
      if (!$isunknown({opcode, funct})) begin
         a_r13_mem_excl: assert (!(mem_rd && mem_wr));
         a_r13_flow_onehot: assert ($onehot0({is_branch, is_jump_reg, is_jump_imm}));
         a_r5_zext_needs_imm: assert (!imm_zero_ext || alu_src_imm);
         a_r6_mem_wb_reads: assert (wb_sel != 2'd1 || (mem_rd && reg_wen));
         a_r9_link_is_jal: assert (dst_sel != 2'd2 || (is_jump_imm && reg_wen && wb_sel == 2'd2));
         a_r11_unknown_idle: assert (op_known || !(reg_wen || mem_rd || mem_wr));
         a_r12_unknown_fn_idle: assert (!is_rtype || fn_known || !(reg_wen || is_jump_reg));
      end
   end

endmodule

// File: tb/insn_ctrl_decoder_test.sv
module insn_ctrl_decoder_test;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [5:0] opcode, funct;
   logic [1:0] dst_sel, wb_sel;
   logic [3:0] alu_op;
   logic reg_wen, alu_src_imm, imm_zero_ext, mem_rd, mem_wr;
   logic is_branch, is_jump_reg, is_jump_imm;

   insn_ctrl_decoder uut (
      .opcode(opcode), .funct(funct), .dst_sel(dst_sel), .reg_wen(reg_wen),
      .wb_sel(wb_sel), .alu_src_imm(alu_src_imm), .imm_zero_ext(imm_zero_ext),
      .alu_op(alu_op), .mem_rd(mem_rd), .mem_wr(mem_wr), .is_branch(is_branch),
      .is_jump_reg(is_jump_reg), .is_jump_imm(is_jump_imm)
   );

   // {dst2, wen, wb2, src, zext, op4, mrd, mwr, br, jreg, jimm}
   typedef struct {
      logic [15:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   function automatic logic [15:0] mk(input logic [1:0] d, input logic w, input logic [1:0] wb,
                                      input logic s, input logic z, input logic [3:0] op,
                                      input logic r, input logic wr, input logic b,
                                      input logic jr, input logic ji);
      return {d, w, wb, s, z, op, r, wr, b, jr, ji};
   endfunction

   function automatic logic [15:0] actual();
      return {dst_sel, reg_wen, wb_sel, alu_src_imm, imm_zero_ext, alu_op,
              mem_rd, mem_wr, is_branch, is_jump_reg, is_jump_imm};
   endfunction

   task automatic drive(input logic [5:0] op, input logic [5:0] fn,
                        input logic [15:0] e, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      opcode = op;
      funct  = fn;
      it.exp = e;
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: results are due in the same cycle, sampled at the falling edge
   always @(negedge clk) begin
      if (!rst && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         n_checks++;
         if (actual() !== it.exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", it.tag, actual(), it.exp);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   localparam logic [15:0] IDLE = 16'h0000;

   initial begin
      opcode = 6'h3F;
      funct  = 6'h00;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R11: idle word after reset on an unused opcode
      drive(6'h3F, 6'h00, IDLE, "R11 opcode 0x3F idle");
      drive(6'h01, 6'h20, IDLE, "R11 opcode 0x01 idle");
      drive(6'h0F, 6'h09, IDLE, "R11 opcode 0x0F idle");

      // R1: register ALU group
      drive(6'h00, 6'h20, mk(0,1,0,0,0,4'd1,0,0,0,0,0), "R1 add");
      drive(6'h00, 6'h21, mk(0,1,0,0,0,4'd2,0,0,0,0,0), "R1 addu");
      drive(6'h00, 6'h22, mk(0,1,0,0,0,4'd3,0,0,0,0,0), "R1 sub");
      drive(6'h00, 6'h23, mk(0,1,0,0,0,4'd4,0,0,0,0,0), "R1 subu");
      drive(6'h00, 6'h24, mk(0,1,0,0,0,4'd5,0,0,0,0,0), "R1 and");
      drive(6'h00, 6'h25, mk(0,1,0,0,0,4'd6,0,0,0,0,0), "R1 or");
      drive(6'h00, 6'h26, mk(0,1,0,0,0,4'd7,0,0,0,0,0), "R1 xor");
      drive(6'h00, 6'h27, mk(0,1,0,0,0,4'd8,0,0,0,0,0), "R1 nor");
      drive(6'h00, 6'h2A, mk(0,1,0,0,0,4'd9,0,0,0,0,0), "R1 slt");
      drive(6'h00, 6'h2B, mk(0,1,0,0,0,4'd10,0,0,0,0,0), "R1 sltu");

      // R2, R3: register jumps
      drive(6'h00, 6'h08, mk(0,0,0,0,0,4'd0,0,0,0,1,0), "R2 jr");
      drive(6'h00, 6'h09, mk(0,1,2,0,0,4'd0,0,0,0,1,0), "R3 jalr");

      // R4, R5: immediate ALU
      drive(6'h08, 6'h00, mk(1,1,0,1,0,4'd1,0,0,0,0,0), "R4 R5 addi sign-ext");
      drive(6'h0B, 6'h00, mk(1,1,0,1,1,4'd10,0,0,0,0,0), "R4 R5 sltiu zero-ext");

      // R6, R7, R8
      drive(6'h23, 6'h00, mk(1,1,1,1,0,4'd1,1,0,0,0,0), "R6 lw");
      drive(6'h2B, 6'h00, mk(0,0,0,1,0,4'd1,0,1,0,0,0), "R7 sw");
      drive(6'h04, 6'h00, mk(0,0,0,0,0,4'd3,0,0,1,0,0), "R8 beq");

      // R9, R10: immediate-target jumps
      drive(6'h03, 6'h00, mk(2,1,2,0,0,4'd0,0,0,0,0,1), "R9 jal");
      drive(6'h02, 6'h00, mk(0,0,0,0,0,4'd0,0,0,0,0,1), "R10 j");

      // R12: unknown function codes under opcode 0x00
      drive(6'h00, 6'h3F, IDLE, "R12 funct 0x3F idle");
      drive(6'h00, 6'h01, IDLE, "R12 funct 0x01 idle");
      drive(6'h00, 6'h0A, IDLE, "R12 funct 0x0A idle");

      // R14: function field ignored outside opcode 0x00
      drive(6'h23, 6'h08, mk(1,1,1,1,0,4'd1,1,0,0,0,0), "R14 lw funct 0x08");
      drive(6'h2B, 6'h3F, mk(0,0,0,1,0,4'd1,0,1,0,0,0), "R14 sw funct 0x3F");
      drive(6'h08, 6'h09, mk(1,1,0,1,0,4'd1,0,0,0,0,0), "R14 addi funct 0x09");
      drive(6'h04, 6'h22, mk(0,0,0,0,0,4'd3,0,0,1,0,0), "R14 beq funct 0x22");
      drive(6'h03, 6'h20, mk(2,1,2,0,0,4'd0,0,0,0,0,1), "R14 jal funct 0x20");
      drive(6'h02, 6'h09, mk(0,0,0,0,0,4'd0,0,0,0,0,1), "R14 j funct 0x09");

      // let the scoreboard drain
      @(posedge clk);
      @(posedge clk);

      // R13 and R5: sweep every opcode, inline checks at the falling edge
      for (int op = 0; op < 64; op++) begin
         @(posedge clk);
         #1;
         opcode = op[5:0];
         funct  = 6'h09;
         @(negedge clk);
         n_checks++;
         if ((mem_rd && mem_wr) ||
             (int'(is_branch) + int'(is_jump_reg) + int'(is_jump_imm) > 1)) begin
            n_errors++;
            $display("FAIL R13 opcode %h: got rd=%b wr=%b flags=%b%b%b expected exclusive",
                     op[5:0], mem_rd, mem_wr, is_branch, is_jump_reg, is_jump_imm);
         end
         n_checks++;
         if (imm_zero_ext !== (op == 'h0B)) begin
            n_errors++;
            $display("FAIL R5 opcode %h: got zext=%b expected %b",
                     op[5:0], imm_zero_ext, (op == 'h0B));
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule